// File: doc/BRIEF.md
# Bitstream Channel Input Port

This block is the entry point for a coded bitstream before it reaches the channel buffer. It has two ways of taking data in. The first is a bit-serial lane: on each rising edge of its own clock, which need not be related to the core clock, it takes one data bit together with a qualifier. The second is a byte-wide lane that uses a request/valid handshake. Serial bits are packed into bytes in their own clock domain. Each packed byte then crosses into the core domain through a small Gray-pointer FIFO. Bytes from either lane land in a core-side FIFO, which stands in for the channel buffer, and a downstream consumer reads them from there.

The port computes its request output from the free space in the buffer. Request is withdrawn while enough room remains for a sender that still pushes a final byte after seeing request go away. If a byte arrives while the buffer is full, the byte is dropped and an overrun is recorded. The overrun stays visible until software acknowledges it. A channel-enable control flushes the buffer and locks out all input while it is low.

Top module: `chin_port`

## Requirements
- R1: While reset is held and just after it is released, `req_n` is 1, `rd_valid` is 0, `stat` is 2'b00 and `irq` is 0.
- R2: In serial mode (`mode_par`=0), a bit is taken on a rising `ser_clk` edge only when `ser_vld` is 1. Every eight taken bits form one byte, with the first bit in bit 7 and the last in bit 0. Cycles with `ser_vld`=0 add nothing.
- R3: In parallel mode (`mode_par`=1), the core clock edge that first sees `par_vld` at 1 writes `par_data`. From then `req_n` reads 1, and it returns to 0 at the edge that first sees `par_vld` back at 0, provided space allows.
- R4: `req_n` is 0 only when `chan_en` is 1, the buffer has at least `MARGIN` free entries and no parallel handshake is pending. With default parameters (16 entries, margin 2), it reads 0 at 14 stored bytes and 1 at 15.
- R5: After `req_n` has gone to 1 for lack of space, one further byte (eight more serial bits) is still stored without an overrun, and `stat` then reads 2'b10 (full).
- R6: A byte that arrives while the buffer holds all entries is discarded. From the next cycle `stat` reads 2'b11 and `irq` is 1.
- R7: Once set, `stat`=2'b11 holds until a one-cycle `stat_rd` pulse. After that pulse it reads 2'b10 while the buffer is full, and 2'b00 once an entry has been read out.
- R8: While `chan_en` is 0, the buffer is emptied and the overrun record is cleared (`rd_valid`=0, `stat`=2'b00, `irq`=0). Parallel writes attempted in this state leave nothing in the buffer.
- R9: Bytes leave in arrival order. `rd_data` shows the oldest byte whenever `rd_valid` is 1, and a cycle with `rd_en`=1 removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| chan_en | input | 1 | Channel enable; 0 flushes the buffer and blocks input |
| mode_par | input | 1 | 1 selects the parallel lane, 0 the serial lane |
| ser_clk | input | 1 | Serial lane clock, asynchronous to `clk` |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Serial bit qualifier |
| par_data | input | W | Parallel data byte, synchronous to `clk` |
| par_vld | input | 1 | Parallel strobe; its rising edge writes |
| req_n | output | 1 | Active-low request for more data |
| rd_en | input | 1 | Consumer pop |
| rd_data | output | W | Oldest buffered byte |
| rd_valid | output | 1 | Buffer not empty |
| stat_rd | input | 1 | Status acknowledge pulse |
| stat | output | 2 | 00 space, 10 full, 11 overrun latched |
| irq | output | 1 | Overrun interrupt, follows the latched overrun |

## Verification
The assertions assume that `par_vld` is synchronous to `clk`. They also assume that `chan_en` and `mode_par` change only while the serial lane is idle, so the serial side always sees a settled enable. The bench drives every core-domain input on the falling edge of `clk` and every serial input on the falling edge of `ser_clk`. It waits several serial clocks after each enable or mode change before it sends serial bits. It also leaves enough core cycles after each serial byte for the pointer synchronizers to settle before it checks anything.

// File: rtl/chin_pkg.sv
package chin_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'b00,
    ST_FULL = 2'b10,
    ST_OVR  = 2'b11
  } chin_stat_e;

  function automatic int unsigned bin2gray(input int unsigned b);
    return b ^ (b >> 1);
  endfunction

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int free_slots(input int depth, input int count);
    return depth - count;
  endfunction

endpackage

// File: rtl/chin_ser_deser.sv
module chin_ser_deser #(
  parameter int BITS = 8
) (
  input  logic            ser_clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ser_bit,
  input  logic            ser_vld,
  output logic            srst_n,
  output logic            byte_vld,
  output logic [BITS-1:0] byte_data
);
  localparam int CNTW = $clog2(BITS);

  logic [1:0]      rst_sync;
  logic [1:0]      en_sync;
  logic [BITS-2:0] shreg;
  logic [CNTW-1:0] bit_cnt;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_ff @(posedge ser_clk or negedge srst_n) begin
    if (!srst_n) en_sync <= 2'b00;
    else         en_sync <= {en_sync[0], en};
  end

  always_ff @(posedge ser_clk or negedge srst_n) begin
    if (!srst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!en_sync[1]) begin
        bit_cnt <= '0;
      end else if (ser_vld) begin
        if (bit_cnt == CNTW'(BITS - 1)) begin
          byte_data <= {shreg, ser_bit};
          byte_vld  <= 1'b1;
          bit_cnt   <= '0;
        end else begin
          shreg   <= {shreg[BITS-3:0], ser_bit};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chin_afifo.sv
module chin_afifo
  import chin_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd,
  output logic         rvalid,
  output logic [W-1:0] rdata
);
  localparam int N  = 1 << AW;
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [N];
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rbin, rgray, wq1, wq2;
  logic          wfull, rempty;

  assign wfull = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});

  always_ff @(posedge wclk) begin
    if (wr && !wfull) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr && !wfull) begin
        wbin  <= wbin + 1'b1;
        wgray <= PW'(bin2gray(32'(wbin + 1'b1)));
      end
    end
  end

  assign rempty = (rgray == wq2);
  assign rvalid = !rempty;
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd && !rempty) begin
        rbin  <= rbin + 1'b1;
        rgray <= PW'(bin2gray(32'(rbin + 1'b1)));
      end
    end
  end
endmodule

// File: rtl/chin_buf.sv
module chin_buf
  import chin_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic          stat_rd,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] count,
  output chin_stat_e    stat,
  output logic          irq,
  output logic          ovr_evt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          ovr_q, full, accept, pop;

  assign full    = (count == CW'(DEPTH));
  assign accept  = wr_req && !full && !flush;
  assign ovr_evt = wr_req && full && !flush;
  assign pop     = rd_en && rd_valid && !flush;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovr_q <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0; ovr_q <= 1'b0;
    end else begin
      if (accept) wp <= AW'(ptr_next(32'(wp), DEPTH));
      if (pop)    rp <= AW'(ptr_next(32'(rp), DEPTH));
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  assign rd_valid = (count != '0);
  assign rd_data  = mem[rp];
  assign irq      = ovr_q;

  always_comb begin
    if (ovr_q)     stat = ST_OVR;
    else if (full) stat = ST_FULL;
    else           stat = ST_OPEN;
  end
endmodule

// File: rtl/chin_port.sv
module chin_port
  import chin_pkg::*;
#(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int MARGIN  = 2,
  parameter int SYNC_AW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         mode_par,
  input  logic         ser_clk,
  input  logic         ser_bit,
  input  logic         ser_vld,
  input  logic [W-1:0] par_data,
  input  logic         par_vld,
  output logic         req_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  input  logic         stat_rd,
  output logic [1:0]   stat,
  output logic         irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic         srst_n, sbyte_vld;
  logic [W-1:0] sbyte;
  logic         cdc_valid;
  logic [W-1:0] cdc_data;
  logic         vld_q, hs_busy;
  logic         par_rise, par_fall;
  logic         wr_req;
  logic [W-1:0] wr_data;
  logic [CW-1:0] buf_count;
  logic         ovr_evt;
  logic         space_ok;
  chin_stat_e   stat_e;

  chin_ser_deser #(.BITS(W)) u_deser (
    .ser_clk   (ser_clk),
    .rst_n     (rst_n),
    .en        (chan_en & ~mode_par),
    .ser_bit   (ser_bit),
    .ser_vld   (ser_vld),
    .srst_n    (srst_n),
    .byte_vld  (sbyte_vld),
    .byte_data (sbyte)
  );

  chin_afifo #(.W(W), .AW(SYNC_AW)) u_cdc (
    .wclk   (ser_clk),
    .wrst_n (srst_n),
    .wr     (sbyte_vld),
    .wdata  (sbyte),
    .rclk   (clk),
    .rrst_n (rst_n),
    .rd     (1'b1),
    .rvalid (cdc_valid),
    .rdata  (cdc_data)
  );

  assign par_rise = mode_par & chan_en & par_vld & ~vld_q;
  assign par_fall = ~par_vld & vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      hs_busy <= 1'b0;
    end else begin
      vld_q <= par_vld;
      if (!chan_en || !mode_par) hs_busy <= 1'b0;
      else if (par_rise)         hs_busy <= 1'b1;
      else if (par_fall)         hs_busy <= 1'b0;
    end
  end

  assign wr_req  = mode_par ? par_rise : (cdc_valid & chan_en);
  assign wr_data = mode_par ? par_data : cdc_data;

  chin_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (~chan_en),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .stat_rd  (stat_rd),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .count    (buf_count),
    .stat     (stat_e),
    .irq      (irq),
    .ovr_evt  (ovr_evt)
  );

  assign space_ok = free_slots(DEPTH, 32'(buf_count)) >= MARGIN;
  assign req_n    = ~(chan_en & space_ok & ~hs_busy);
  assign stat     = stat_e;
endmodule

// File: rtl/chin_port_chk.sv
module chin_port_chk #(
  parameter int DEPTH  = 16,
  parameter int MARGIN = 2,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          mode_par,
  input logic          par_vld,
  input logic          req_n,
  input logic          rd_valid,
  input logic [1:0]    stat,
  input logic          irq,
  input logic          stat_rd,
  input logic [CW-1:0] buf_count,
  input logic          ovr_evt
);
  // R3
  par_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_vld) && mode_par && chan_en |=> req_n);

  // R4
  req_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> chan_en && (int'(DEPTH) - int'(buf_count) >= MARGIN));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_count) <= DEPTH);

  // R6
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (stat == 2'b11) && irq);

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 2'b11) && !stat_rd && chan_en |=> (stat == 2'b11));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !rd_valid && (stat == 2'b00) && !irq);
endmodule

bind chin_port chin_port_chk #(.DEPTH(DEPTH), .MARGIN(MARGIN), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .mode_par  (mode_par),
  .par_vld   (par_vld),
  .req_n     (req_n),
  .rd_valid  (rd_valid),
  .stat      (stat),
  .irq       (irq),
  .stat_rd   (stat_rd),
  .buf_count (buf_count),
  .ovr_evt   (ovr_evt)
);

// File: tb/chin_port_tb.sv
module chin_port_tb;
  localparam int DEPTH  = 16;
  localparam int MARGIN = 2;

  logic       clk = 1'b0, ser_clk = 1'b0;
  logic       rst_n, chan_en, mode_par, ser_bit, ser_vld, par_vld, rd_en, stat_rd;
  logic [7:0] par_data, rd_data;
  logic       req_n, rd_valid, irq;
  logic [1:0] stat;
  int         errors = 0, checks = 0;

  always #4  clk = ~clk;
  always #10 ser_clk = ~ser_clk;

  chin_port u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_par(mode_par),
    .ser_clk(ser_clk), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .par_data(par_data), .par_vld(par_vld), .req_n(req_n),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .stat_rd(stat_rd), .stat(stat), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ser_byte(input logic [7:0] b, input bit gaps);
    for (int i = 7; i >= 0; i--) begin
      @(negedge ser_clk); ser_bit = b[i]; ser_vld = 1'b1;
      if (gaps) begin
        @(negedge ser_clk); ser_vld = 1'b0; ser_bit = ~b[i];
      end
    end
    @(negedge ser_clk); ser_vld = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic par_byte(input logic [7:0] b);
    for (int t = 0; t < 50 && req_n; t++) @(negedge clk);
    par_data = b; par_vld = 1'b1;
    @(negedge clk);
    chk("R3 req_n after rise", req_n, 1'b1);
    par_vld = 1'b0;
    @(negedge clk);
    chk("R3 req_n after fall", req_n, 1'b0);
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] exp);
    chk({tag, " rd_valid"}, rd_valid, 1'b1);
    chk({tag, " rd_data"}, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chan_en = 1'b0; mode_par = 1'b0; ser_bit = 1'b0; ser_vld = 1'b0;
    par_vld = 1'b0; par_data = '0; rd_en = 1'b0; stat_rd = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 req_n in reset", req_n, 1'b1);
    rst_n = 1'b1;
    repeat (6) @(negedge ser_clk);
    @(negedge clk);
    chk("R1 req_n", req_n, 1'b1);
    chk("R1 rd_valid", rd_valid, 1'b0);
    chk("R1 stat", stat, 2'b00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_parallel();
    mode_par = 1'b1; chan_en = 1'b1;
    @(negedge clk);
    chk("R4 req_n low when empty", req_n, 1'b0);
    par_byte(8'hA5);
    par_byte(8'h3C);
    pop_expect("R9 first", 8'hA5);
    pop_expect("R9 second", 8'h3C);
    chk("R9 drained", rd_valid, 1'b0);
  endtask

  task automatic t_serial();
    mode_par = 1'b0;
    repeat (6) @(negedge ser_clk);
    ser_byte(8'hD2, 1'b1);
    pop_expect("R2 gapped MSB first", 8'hD2);
    ser_byte(8'h81, 1'b0);
    pop_expect("R2 back to back", 8'h81);
    chk("R2 no extra byte", rd_valid, 1'b0);
  endtask

  task automatic t_fill_overrun();
    for (int k = 0; k < DEPTH - 1; k++) begin
      ser_byte(8'(k * 7 + 1), 1'b0);
      if (k == DEPTH - MARGIN - 1) chk("R4 req_n low at 14", req_n, 1'b0);
    end
    chk("R4 req_n high at 15", req_n, 1'b1);
    ser_byte(8'hEE, 1'b0);
    chk("R5 grace byte stored, stat full", stat, 2'b10);
    chk("R5 no irq", irq, 1'b0);
    ser_byte(8'h77, 1'b0);
    chk("R6 overrun stat", stat, 2'b11);
    chk("R6 irq", irq, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 overrun holds", stat, 2'b11);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk("R7 after read full", stat, 2'b10);
    pop_expect("R9 oldest after fill", 8'h01);
    chk("R7 space freed", stat, 2'b00);
    pop_expect("R9 second after fill", 8'h08);
    ser_byte(8'h55, 1'b0);
    ser_byte(8'h66, 1'b0);
    ser_byte(8'h99, 1'b0);
    chk("R6 second overrun", stat, 2'b11);
  endtask

  task automatic t_disable();
    chan_en = 1'b0;
    @(negedge clk);
    chk("R8 flushed rd_valid", rd_valid, 1'b0);
    chk("R8 stat cleared", stat, 2'b00);
    chk("R8 irq cleared", irq, 1'b0);
    chk("R8 req_n high", req_n, 1'b1);
    mode_par = 1'b1; par_data = 8'h42; par_vld = 1'b1;
    @(negedge clk); par_vld = 1'b0;
    @(negedge clk);
    chk("R8 write ignored", rd_valid, 1'b0);
    chan_en = 1'b1;
    @(negedge clk);
    chk("R8 nothing stale after enable", rd_valid, 1'b0);
    chk("R8 stat after enable", stat, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_parallel();
    t_serial();
    t_fill_overrun();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule